// File: doc/BRIEF.md
# Three-Phase Gate Interlock

This block guards six gate-drive outputs of a three-phase bridge. Each phase has a high-side and a low-side PWM command, and the block decides, cycle by cycle, whether each command may reach its gate. It never lets both gates of one phase conduct together. It turns every gate off while the bridge is disabled, while an overcurrent fault is active, or while the main supply is flagged as low. It turns off a single phase's high-side gate while that phase's bootstrap supply is flagged as low.

After the main supply recovers, the high side of each phase stays off until that phase's low-side command has been seen asserted. This ensures the bootstrap capacitor has had a chance to charge. The PWM commands are asynchronous to the block clock and pass through a synchronizer. The enable, fault and undervoltage flags arrive already debounced and synchronous to the clock.

Top module: `phase_gate_guard`

## Requirements
- R1: When a phase's high and low commands are both 1, both gates of that phase are 0.
- R2: When only the high command of a phase is 1, its high gate is 1 and its low gate is 0, provided the phase is armed and no block applies. When only the low command is 1, the low gate is 1 and the high gate is 0. When neither command is 1, both gates are 0. Bit 0 is phase U, bit 1 is phase V and bit 2 is phase W on every three-bit port.
- R3: While `enable` is 0, all six gates are 0, whatever the commands are.
- R4: While `ocFault` is 1, all six gates are 0.
- R5: While `supplyLow` is 1, all six gates are 0. Once it returns to 0, low-side gates follow their commands again.
- R6: A 1 on `supplyLow` disarms every high side. After it clears, a phase's high gate stays 0 until that phase's synchronized low command has been 1. Each phase is armed independently of the others.
- R7: A 1 on `bootLow[i]` forces `hiGate[i]` to 0 and leaves every other gate alone. The high gate follows its command again on the cycle after the flag clears.
- R8: During reset all gates are 0. After reset every high side starts unarmed, as in R6.
- R9: A PWM command change reaches its gate after three rising clock edges: two synchronizer stages and one output register. A change on `enable`, `ocFault`, `supplyLow` or `bootLow` reaches the gates after one rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 lets the gates follow their commands |
| ocFault | input | 1 | Overcurrent fault, 1 forces all gates off |
| supplyLow | input | 1 | Main-supply undervoltage flag, 1 forces all off and disarms |
| bootLow | input | 3 | Per-phase bootstrap undervoltage flag (bit 0 = U) |
| hiCmd | input | 3 | High-side PWM commands, asynchronous |
| loCmd | input | 3 | Low-side PWM commands, asynchronous |
| hiGate | output | 3 | Registered high-side gate drives |
| loGate | output | 3 | Registered low-side gate drives |

## Verification
The hardest situation to reach is the per-phase arming after supply recovery. Arming state cannot be seen directly at the ports, so it has to be inferred from a high gate that stays off while its command is on. The stimulus raises `supplyLow` with all high commands on, then clears it. It then applies a low command to phase U alone and returns all three high commands. Only phase U's high gate may turn on. Phases V and W must stay off until their own low commands have passed through the synchronizer.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;
  localparam int unsigned PHASE_COUNT = 3;

  typedef struct packed {
    logic                   forceOff;
    logic [PHASE_COUNT-1:0] hiBlock;
  } guardStrobes_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import gate_guard_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   ocFault,
  input  logic                   supplyLow,
  input  logic [PHASE_COUNT-1:0] bootLow,
  input  logic [PHASE_COUNT-1:0] syncLo,
  output guardStrobes_t          strobes
);
  logic [PHASE_COUNT-1:0] armed;

  // A high side is armed once its low command has been seen with the supply good.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= '0;
    else if (supplyLow) armed <= '0;
    else                armed <= armed | syncLo;
  end

  always_comb begin
    strobes.forceOff = !enable || ocFault || supplyLow;
    strobes.hiBlock  = bootLow | ~armed;
  end
endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import gate_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PHASE_COUNT-1:0] hiCmd,
  input  logic [PHASE_COUNT-1:0] loCmd,
  input  guardStrobes_t          strobes,
  output logic [PHASE_COUNT-1:0] syncLo,
  output logic [PHASE_COUNT-1:0] hiGate,
  output logic [PHASE_COUNT-1:0] loGate
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][PHASE_COUNT-1:0] hiPipe;
  logic [SYNC_STAGES-1:0][PHASE_COUNT-1:0] loPipe;
  logic [PHASE_COUNT-1:0] hiNext;
  logic [PHASE_COUNT-1:0] loNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPipe <= '0;
      loPipe <= '0;
    end else begin
      hiPipe[0] <= hiCmd;
      loPipe[0] <= loCmd;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        hiPipe[s] <= hiPipe[s-1];
        loPipe[s] <= loPipe[s-1];
      end
    end
  end

  assign syncLo = loPipe[LAST];

  for (genvar p = 0; p < PHASE_COUNT; p++) begin : g_phase
    logic hiReq;
    logic loReq;
    assign hiReq = hiPipe[LAST][p];
    assign loReq = loPipe[LAST][p];
    always_comb begin
      hiNext[p] = hiReq && !loReq && !strobes.forceOff && !strobes.hiBlock[p];
      loNext[p] = loReq && !hiReq && !strobes.forceOff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiGate <= '0;
      loGate <= '0;
    end else begin
      hiGate <= hiNext;
      loGate <= loNext;
    end
  end
endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard
  import gate_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ocFault,
  input  logic       supplyLow,
  input  logic [2:0] bootLow,
  input  logic [2:0] hiCmd,
  input  logic [2:0] loCmd,
  output logic [2:0] hiGate,
  output logic [2:0] loGate
);
  guardStrobes_t          strobes;
  logic [PHASE_COUNT-1:0] syncLo;

  guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .ocFault(ocFault),
    .supplyLow(supplyLow), .bootLow(bootLow), .syncLo(syncLo),
    .strobes(strobes)
  );

  guard_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .hiCmd(hiCmd), .loCmd(loCmd),
    .strobes(strobes), .syncLo(syncLo), .hiGate(hiGate), .loGate(loGate)
  );
endmodule

// File: rtl/phase_gate_guard_checker.sv
module phase_gate_guard_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       ocFault,
  input logic       supplyLow,
  input logic [2:0] bootLow,
  input logic [2:0] hiGate,
  input logic [2:0] loGate
);
  p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hiGate & loGate) == 3'b000);

  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hiGate == 3'b000 && loGate == 3'b000));

  p_fault_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    ocFault |=> (hiGate == 3'b000 && loGate == 3'b000));

  p_supply_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> (hiGate == 3'b000 && loGate == 3'b000));

  p_boot_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bootLow != 3'b000) |=> ((hiGate & $past(bootLow)) == 3'b000));

  // R6: a high gate cannot rise in the cycle right after a supply-low cycle
  p_no_hi_after_uv_r6: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> ##1 (hiGate == 3'b000));
endmodule

bind phase_gate_guard phase_gate_guard_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ocFault(ocFault),
  .supplyLow(supplyLow), .bootLow(bootLow), .hiGate(hiGate), .loGate(loGate)
);

// File: tb/phase_gate_guard_test.sv
module phase_gate_guard_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic ocFault = 1'b0;
  logic supplyLow = 1'b0;
  logic [2:0] bootLow = 3'b000;
  logic [2:0] hiCmd = 3'b000;
  logic [2:0] loCmd = 3'b000;
  logic [2:0] hiGate;
  logic [2:0] loGate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_gate_guard uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ocFault(ocFault),
    .supplyLow(supplyLow), .bootLow(bootLow), .hiCmd(hiCmd), .loCmd(loCmd),
    .hiGate(hiGate), .loGate(loGate)
  );

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCmd(input logic [2:0] hi, input logic [2:0] lo);
    hiCmd = hi;
    loCmd = lo;
  endtask

  task automatic testReset();
    waitNeg(2);
    check("R8", "hi during reset", hiGate, 3'b000);
    check("R8", "lo during reset", loGate, 3'b000);
    rstN = 1'b1;
    setCmd(3'b001, 3'b000);
    waitNeg(5);
    check("R8", "hi unarmed after reset", hiGate, 3'b000);
    setCmd(3'b000, 3'b000);
    waitNeg(4);
  endtask

  task automatic armAll();
    setCmd(3'b000, 3'b111);
    waitNeg(4);
    check("R2", "low side only", loGate, 3'b111);
    check("R2", "high off with low", hiGate, 3'b000);
    setCmd(3'b000, 3'b000);
    waitNeg(4);
  endtask

  task automatic testDecode();
    setCmd(3'b001, 3'b010);
    waitNeg(3);
    check("R2", "hi U", hiGate, 3'b001);
    check("R2", "lo V", loGate, 3'b010);
    setCmd(3'b101, 3'b100);
    waitNeg(3);
    check("R1", "both W hi", hiGate, 3'b001);
    check("R1", "both W lo", loGate, 3'b000);
    setCmd(3'b000, 3'b000);
    waitNeg(3);
    check("R2", "neither hi", hiGate, 3'b000);
    check("R2", "neither lo", loGate, 3'b000);
  endtask

  task automatic testLatency();
    setCmd(3'b010, 3'b000);
    waitNeg(2);
    check("R9", "hi not yet after two edges", hiGate, 3'b000);
    waitNeg(1);
    check("R9", "hi after three edges", hiGate, 3'b010);
    enable = 1'b0;
    waitNeg(1);
    check("R9", "flag after one edge", hiGate, 3'b000);
    enable = 1'b1;
    waitNeg(1);
    check("R9", "flag release one edge", hiGate, 3'b010);
    setCmd(3'b000, 3'b000);
    waitNeg(3);
  endtask

  task automatic testEnable();
    setCmd(3'b100, 3'b011);
    waitNeg(3);
    check("R3", "enabled hi", hiGate, 3'b100);
    enable = 1'b0;
    waitNeg(2);
    check("R3", "disabled hi", hiGate, 3'b000);
    check("R3", "disabled lo", loGate, 3'b000);
    enable = 1'b1;
    waitNeg(1);
    check("R3", "re-enabled lo", loGate, 3'b011);
  endtask

  task automatic testFault();
    ocFault = 1'b1;
    waitNeg(1);
    check("R4", "fault hi", hiGate, 3'b000);
    check("R4", "fault lo", loGate, 3'b000);
    ocFault = 1'b0;
    waitNeg(1);
    check("R4", "fault cleared hi", hiGate, 3'b100);
    setCmd(3'b000, 3'b000);
    waitNeg(3);
  endtask

  task automatic testBoot();
    setCmd(3'b111, 3'b000);
    waitNeg(3);
    check("R7", "all hi on", hiGate, 3'b111);
    bootLow = 3'b010;
    waitNeg(1);
    check("R7", "V hi blocked only", hiGate, 3'b101);
    bootLow = 3'b000;
    waitNeg(1);
    check("R7", "V hi restored", hiGate, 3'b111);
    setCmd(3'b101, 3'b010);
    bootLow = 3'b010;
    waitNeg(3);
    check("R7", "lo V untouched", loGate, 3'b010);
    check("R7", "hi U W untouched", hiGate, 3'b101);
    bootLow = 3'b000;
  endtask

  task automatic testSupply();
    setCmd(3'b111, 3'b000);
    waitNeg(3);
    supplyLow = 1'b1;
    waitNeg(1);
    check("R5", "uv hi", hiGate, 3'b000);
    supplyLow = 1'b0;
    waitNeg(4);
    check("R6", "hi held after recovery", hiGate, 3'b000);
    setCmd(3'b110, 3'b001);
    waitNeg(3);
    check("R5", "lo U resumes", loGate, 3'b001);
    check("R6", "V W still unarmed", hiGate, 3'b000);
    setCmd(3'b111, 3'b000);
    waitNeg(3);
    check("R6", "only U rearmed", hiGate, 3'b001);
    setCmd(3'b000, 3'b000);
    waitNeg(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    armAll();
    testDecode();
    testLatency();
    testEnable();
    testFault();
    testBoot();
    testSupply();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule